// File: doc/BRIEF.md
# Fault-Bypassable Weight-Stationary MAC Grid

This block is a two-dimensional grid of signed multiply-accumulate elements. Each element holds one weight. The grid is loaded one row of weights at a time from the top edge. After loading, each weight stays in its element while activation vectors stream through. The weights of one neuron sit in one column, so the grid evaluates COLS neurons at once. Each activation vector enters at the left edge with one value per row. It is skewed internally so that each row meets the partial sum coming down its column at the right moment. The column sums leave the bottom row, are realigned, and are folded into one accumulator per column.

A dot product longer than the grid height is processed as several chunks, with new weights loaded between chunks. A start flag on a vector restarts the column accumulators. An end flag on a vector releases the accumulated result. Every element also holds a bypass bit, written through a serial configuration chain after manufacturing test. A set bit makes the element forward the partial sum from above unchanged. A faulty multiplier therefore acts as a zero weight instead of corrupting the column.

Top module: `bmg_grid`

## Requirements
- R1: A synchronous active-high `rst` clears all weights, all bypass bits, the accumulators and `y_vec`, and holds `y_valid` low. Any vector sent after reset, before new weights are loaded, yields 0 in every column.
- R2: Each cycle with `w_shift` high writes `w_row` into the top row and moves every row down by one. After ROWS such cycles, row r holds the word given on pulse ROWS-1-r. The weight of column c is `w_row[c*DW +: DW]` (signed two's complement).
- R3: For a vector sent with both flags set, column c of `y_vec` (`y_vec[c*AW +: AW]`, signed) equals the sum over rows r of `a_vec[r*DW +: DW]` times weight(r,c), over the elements that are not bypassed.
- R4: For an isolated vector, `y_valid` first goes high after the (ROWS+COLS+1)-th rising edge that follows the edge sampling `a_valid` with `a_last` set.
- R5: Vectors may arrive on consecutive cycles. Each vector with `a_last` produces exactly one `y_valid` cycle, in issue order, with no lost or extra results.
- R6: A bypassed element adds nothing to its column. Its activation still reaches the elements to its right. A column whose elements are all bypassed yields 0.
- R7: Each cycle with `f_shift` high shifts `f_bit` into element index 0 and moves the bit at index k to index k+1, where index = row*COLS + col. A 1 means bypass.
- R8: Bypass bits are unaffected by weight loads and by streaming. They change only through the chain or through reset.
- R9: A vector with `a_first` replaces the column accumulators with its own column sums. A vector without `a_first` adds to them. Only vectors with `a_last` raise `y_valid`, so a multi-chunk dot product with weight reloads between chunks gives the sum over all chunks.
- R10: `y_vec` holds its value in every cycle in which `y_valid` is low.
- R11: No intermediate overflow occurs. Each column sum keeps 2*DW + clog2(ROWS) bits, and AW adds ACC_GUARD more bits for chunks. With all weights and activations at the most negative value, the result is ROWS * 2^(2*DW-2) per chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| w_shift | input | 1 | Shift `w_row` into the top weight row |
| w_row | input | COLS*DW | One row of signed weights, column c at bits c*DW |
| f_shift | input | 1 | Shift the bypass configuration chain |
| f_bit | input | 1 | Bypass bit entering element index 0 |
| a_valid | input | 1 | Activation vector present |
| a_first | input | 1 | Vector opens a new dot product |
| a_last | input | 1 | Vector closes the dot product and releases the result |
| a_vec | input | ROWS*DW | Signed activations, row r at bits r*DW |
| y_valid | output | 1 | Result vector valid for one cycle |
| y_vec | output | COLS*AW | Signed column results, column c at bits c*AW |

## Verification
The bench targets the cases where timing or masking slips without any obvious symptom. Back-to-back vectors with distinct patterns expose a wrong skew or de-skew depth, because a misaligned design mixes activations from neighbouring vectors into a column. Single and whole-column bypass maps, checked against a model that zeroes bypassed weights, show a reversed chain order or a multiplexer on the wrong path as mismatches in one column. A weight reload between the chunks of a single dot product, a start vector without an end, and full-scale negative operands catch accumulators that clear wrongly, release early, change the output while it is not valid, or truncate the sum.

// File: rtl/bmg_pkg.sv
package bmg_pkg;
  // Control flags that travel alongside a vector through the grid.
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } bmg_tag_t;
endpackage

// File: rtl/bmg_delay.sv
// Fixed-depth register delay line with synchronous reset.
module bmg_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[DEPTH-1];
endmodule

// File: rtl/bmg_wbank.sv
// Stationary weight storage, filled from the top one row per shift.
module bmg_wbank #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     w_shift,
  input  logic [COLS*DW-1:0]       w_row,
  output logic [ROWS*COLS*DW-1:0]  wts
);
  localparam int RW = COLS * DW;

  logic [RW-1:0] rows [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) rows[r] <= '0;
    end else if (w_shift) begin
      rows[0] <= w_row;
      for (int r = 1; r < ROWS; r++) rows[r] <= rows[r-1];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_out
    assign wts[r*RW +: RW] = rows[r];
  end
endmodule

// File: rtl/bmg_fault_cfg.sv
// Serial chain holding one bypass bit per processing element.
module bmg_fault_cfg #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         f_shift,
  input  logic         f_bit,
  output logic [N-1:0] byp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byp <= '0;
    end else if (f_shift) begin
      byp <= N'({byp, f_bit});
    end
  end
endmodule

// File: rtl/bmg_pe.sv
// One element: registered partial sum, MAC skipped when bypassed.
module bmg_pe #(
  parameter int DW  = 8,
  parameter int PSW = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [DW-1:0]  act,
  input  logic signed [DW-1:0]  wt,
  input  logic                  byp,
  input  logic signed [PSW-1:0] psum_in,
  output logic signed [PSW-1:0] psum_out
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0]  prod;
  logic signed [PSW-1:0] mac;

  assign prod = PW'(act) * PW'(wt);
  assign mac  = psum_in + PSW'(prod);

  always_ff @(posedge clk) begin
    if (rst) psum_out <= '0;
    else     psum_out <= byp ? psum_in : mac;
  end
endmodule

// File: rtl/bmg_colacc.sv
// Per-column accumulator that combines chunk results.
module bmg_colacc #(
  parameter int PSW = 18,
  parameter int AW  = 26
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vld,
  input  logic                  first,
  input  logic                  last,
  input  logic signed [PSW-1:0] val,
  output logic signed [AW-1:0]  y
);
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] nxt;

  assign nxt = first ? AW'(val) : acc + AW'(val);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      y   <= '0;
    end else if (vld) begin
      acc <= nxt;
      if (last) y <= nxt;
    end
  end
endmodule

// File: rtl/bmg_grid.sv
module bmg_grid #(
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int DW        = 8,
  parameter int ACC_GUARD = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     w_shift,
  input  logic [COLS*DW-1:0]       w_row,
  input  logic                     f_shift,
  input  logic                     f_bit,
  input  logic                     a_valid,
  input  logic                     a_first,
  input  logic                     a_last,
  input  logic [ROWS*DW-1:0]       a_vec,
  output logic                     y_valid,
  output logic [COLS*(2*DW+$clog2(ROWS)+ACC_GUARD)-1:0] y_vec
);
  import bmg_pkg::*;

  localparam int PSW  = 2 * DW + $clog2(ROWS);
  localparam int AW   = PSW + ACC_GUARD;
  localparam int NPE  = ROWS * COLS;
  localparam int TLAT = ROWS + COLS + 1;

  logic [NPE*DW-1:0]     wts;
  logic [NPE-1:0]        byp_bits;
  logic signed [PSW-1:0] psum_v  [ROWS][COLS];
  logic signed [PSW-1:0] col_out [COLS];
  bmg_tag_t              tag_d, tag_q;

  bmg_wbank #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_wbank (
    .clk(clk), .rst(rst), .w_shift(w_shift), .w_row(w_row), .wts(wts)
  );

  bmg_fault_cfg #(.N(NPE)) u_fcfg (
    .clk(clk), .rst(rst), .f_shift(f_shift), .f_bit(f_bit), .byp(byp_bits)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    // Row r sees its activation r cycles late; each column adds one more.
    logic signed [DW-1:0] pipe [r+COLS];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < r + COLS; i++) pipe[i] <= '0;
      end else begin
        pipe[0] <= a_vec[r*DW +: DW];
        for (int i = 1; i < r + COLS; i++) pipe[i] <= pipe[i-1];
      end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
      if (r == 0) begin : g_top
        bmg_pe #(.DW(DW), .PSW(PSW)) u_pe (
          .clk(clk), .rst(rst),
          .act(pipe[r+c]),
          .wt(wts[(r*COLS+c)*DW +: DW]),
          .byp(byp_bits[r*COLS+c]),
          .psum_in('0),
          .psum_out(psum_v[r][c])
        );
      end else begin : g_mid
        bmg_pe #(.DW(DW), .PSW(PSW)) u_pe (
          .clk(clk), .rst(rst),
          .act(pipe[r+c]),
          .wt(wts[(r*COLS+c)*DW +: DW]),
          .byp(byp_bits[r*COLS+c]),
          .psum_in(psum_v[r-1][c]),
          .psum_out(psum_v[r][c])
        );
      end
    end
  end

  assign tag_d = '{vld: a_valid, first: a_first, last: a_last};

  bmg_delay #(.W($bits(bmg_tag_t)), .DEPTH(TLAT)) u_tagdly (
    .clk(clk), .rst(rst), .d(tag_d), .q(tag_q)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_acc
    // Earlier columns finish first; pad them so all columns line up.
    bmg_delay #(.W(PSW), .DEPTH(COLS - c)) u_deskew (
      .clk(clk), .rst(rst), .d(psum_v[ROWS-1][c]), .q(col_out[c])
    );

    bmg_colacc #(.PSW(PSW), .AW(AW)) u_acc (
      .clk(clk), .rst(rst),
      .vld(tag_q.vld), .first(tag_q.first), .last(tag_q.last),
      .val(col_out[c]),
      .y(y_vec[c*AW +: AW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) y_valid <= 1'b0;
    else     y_valid <= tag_q.vld && tag_q.last;
  end
endmodule

// File: rtl/bmg_grid_chk.sv
module bmg_grid_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  parameter int AW   = 26
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    w_shift,
  input logic                    f_shift,
  input logic                    a_valid,
  input logic                    a_last,
  input logic                    y_valid,
  input logic [COLS*AW-1:0]      y_vec,
  input logic [ROWS*COLS*DW-1:0] wts,
  input logic [ROWS*COLS-1:0]    byp_bits
);
  // Results owed: vectors issued with a_last minus results delivered.
  logic [7:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      case ({a_valid && a_last, y_valid})
        2'b10:   pend <= pend + 8'd1;
        2'b01:   pend <= pend - 8'd1;
        default: pend <= pend;
      endcase
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !y_valid);

  p_weights_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !w_shift |=> $stable(wts));

  p_bypass_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !f_shift |=> $stable(byp_bits));

  p_result_owed_r9: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> pend != 8'd0);

  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !y_valid |-> $stable(y_vec));
endmodule

bind bmg_grid bmg_grid_chk #(
  .ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .w_shift(w_shift), .f_shift(f_shift),
  .a_valid(a_valid), .a_last(a_last), .y_valid(y_valid), .y_vec(y_vec),
  .wts(wts), .byp_bits(byp_bits)
);

// File: tb/sim_bmg_grid.sv
`timescale 1ns/1ps
module sim_bmg_grid;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DW   = 8;
  localparam int AW   = 2*DW + 2 + 8;
  localparam int NPE  = ROWS * COLS;

  // {first, last, a_vec}: row r activation at bits r*8.
  localparam logic [33:0] TBL [8] = '{
    34'h3_01020304, 34'h3_FF7F8001, 34'h2_10F00A05, 34'h0_03030303,
    34'h1_FE01FE01, 34'h3_80808080, 34'h3_00000000, 34'h3_7F7F7F7F
  };

  logic clk = 1'b0;
  logic rst;
  logic w_shift, f_shift, f_bit, a_valid, a_first, a_last, y_valid;
  logic [COLS*DW-1:0] w_row;
  logic [ROWS*DW-1:0] a_vec;
  logic [COLS*AW-1:0] y_vec;

  always #2.5 clk = ~clk;

  bmg_grid u0 (
    .clk(clk), .rst(rst), .w_shift(w_shift), .w_row(w_row),
    .f_shift(f_shift), .f_bit(f_bit), .a_valid(a_valid),
    .a_first(a_first), .a_last(a_last), .a_vec(a_vec),
    .y_valid(y_valid), .y_vec(y_vec)
  );

  int w_m [ROWS][COLS];
  int w_next [ROWS][COLS];
  bit f_m [ROWS][COLS];
  bit f_next [ROWS][COLS];
  int b_acc [COLS];
  logic [COLS*32-1:0] exp_q [$];
  logic [COLS*32-1:0] e_cur;
  logic [COLS*AW-1:0] last_y;
  string cur_req = "R1";
  int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0, out_cnt = 0;
  bit done = 0;

  // Scoreboard: every result is compared with the masked-weight model.
  always @(negedge clk) begin
    if (!rst && y_valid) begin
      out_cnt++;
      if (exp_q.size() == 0) begin
        mon_checks++; mon_fails++;
        $display("FAIL %s unexpected result: got y_valid=1 exp no result", cur_req);
      end else begin
        e_cur = exp_q.pop_front();
        for (int c = 0; c < COLS; c++) begin
          int got, exv;
          got = $signed(y_vec[c*AW +: AW]);
          exv = $signed(e_cur[c*32 +: 32]);
          mon_checks++;
          if (got != exv) begin
            mon_fails++;
            $display("FAIL %s col %0d: got %0d exp %0d", cur_req, c, got, exv);
          end
        end
      end
      last_y = y_vec;
    end
  end

  task automatic chk(input bit ok, input string req, input int got, input int exv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", req, got, exv);
    end
  endtask

  task automatic send(input logic [33:0] ent);
    @(negedge clk);
    a_valid = 1'b1; a_first = ent[33]; a_last = ent[32]; a_vec = ent[31:0];
    for (int c = 0; c < COLS; c++) begin
      int dot = 0;
      for (int r = 0; r < ROWS; r++) begin
        int av;
        av = $signed(ent[r*8 +: 8]);
        if (!f_m[r][c]) dot += av * w_m[r][c];
      end
      if (ent[33]) b_acc[c] = dot;
      else         b_acc[c] += dot;
    end
    if (ent[32]) begin
      logic [COLS*32-1:0] ev;
      for (int c = 0; c < COLS; c++) ev[c*32 +: 32] = b_acc[c];
      exp_q.push_back(ev);
    end
  endtask

  task automatic idle_drain();
    @(negedge clk);
    a_valid = 1'b0; a_first = 1'b0; a_last = 1'b0;
    repeat (ROWS + COLS + 4) @(negedge clk);
  endtask

  task automatic load_weights();
    for (int k = 0; k < ROWS; k++) begin
      @(negedge clk);
      w_shift = 1'b1;
      for (int c = 0; c < COLS; c++) w_row[c*8 +: 8] = w_next[ROWS-1-k][c][7:0];
    end
    @(negedge clk);
    w_shift = 1'b0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) w_m[r][c] = w_next[r][c];
  endtask

  task automatic load_faults();
    for (int k = 0; k < NPE; k++) begin
      int idx;
      idx = NPE - 1 - k;
      @(negedge clk);
      f_shift = 1'b1;
      f_bit = f_next[idx / COLS][idx % COLS];
    end
    @(negedge clk);
    f_shift = 1'b0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) f_m[r][c] = f_next[r][c];
  endtask

  task automatic set_faults_none();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) f_next[r][c] = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      $display("FAIL R5 watchdog expired: got hung run exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1,
               fails + mon_fails + 1);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; w_shift = 0; f_shift = 0; f_bit = 0;
    a_valid = 0; a_first = 0; a_last = 0; w_row = '0; a_vec = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin w_m[r][c] = 0; f_m[r][c] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: quiet after reset; zero weights give zero results.
    @(negedge clk);
    chk(y_valid == 1'b0, "R1 y_valid after reset", int'(y_valid), 0);

    // R4: isolated vector latency, counted in falling edges.
    cur_req = "R1 R4";
    begin
      int k;
      send(34'h3_05050505);
      k = 0;
      for (int i = 1; i <= 30; i++) begin
        @(negedge clk);
        if (i == 1) begin a_valid = 0; a_first = 0; a_last = 0; end
        if (y_valid && k == 0) k = i;
      end
      chk(k == ROWS + COLS + 2, "R4 latency", k, ROWS + COLS + 2);
    end

    // R2 R3 R5 R6: back-to-back table with a sparse fault map.
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) w_next[r][c] = (r*COLS + c)*7 - 50;
    load_weights();
    set_faults_none();
    f_next[0][1] = 1; f_next[2][3] = 1; f_next[3][0] = 1;
    load_faults();
    cur_req = "R2 R3 R5 R6";
    for (int i = 0; i < 8; i++) send(TBL[i]);
    idle_drain();

    // R6: a whole column bypassed plus one more element.
    set_faults_none();
    for (int r = 0; r < ROWS; r++) f_next[r][2] = 1;
    f_next[1][0] = 1;
    load_faults();
    cur_req = "R6";
    send(TBL[0]); send(TBL[1]); send(TBL[7]);
    idle_drain();

    // R7: single bypass at index 9 (row 2, col 1); col1 expects 3.
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) w_next[r][c] = 1;
    load_weights();
    set_faults_none();
    f_next[2][1] = 1;
    load_faults();
    cur_req = "R7";
    send(34'h3_01010101);
    idle_drain();

    // R8: new weights, bypass map kept.
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) w_next[r][c] = 3 - r + 2*c;
    load_weights();
    cur_req = "R8";
    send(TBL[0]); send(TBL[7]);
    idle_drain();

    // R9 R10: two chunks with a weight reload between them.
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) w_next[r][c] = (r*COLS + c)*7 - 50;
    load_weights();
    cur_req = "R9";
    begin
      logic [COLS*AW-1:0] snap;
      int cnt0;
      snap = y_vec;
      cnt0 = out_cnt;
      send(34'h2_FF7F8001);
      idle_drain();
      chk(out_cnt == cnt0, "R9 no result without last", out_cnt, cnt0);
      chk(y_vec == snap, "R10 y_vec held while not valid", int'(y_vec[31:0]),
          int'(snap[31:0]));
      chk(y_vec == last_y, "R10 y_vec equals last result", int'(y_vec[AW-1:0]),
          int'(last_y[AW-1:0]));
    end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) w_next[r][c] = 3 - r + 2*c;
    load_weights();
    send(34'h1_10F00A05);
    idle_drain();

    // R11: full negative range, one chunk then two chunks.
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) w_next[r][c] = -128;
    load_weights();
    set_faults_none();
    load_faults();
    cur_req = "R11";
    send(34'h3_80808080);
    send(34'h2_80808080);
    send(34'h1_80808080);
    idle_drain();
    chk(b_acc[0] == 2 * ROWS * 16384, "R11 model two-chunk value", b_acc[0],
        2 * ROWS * 16384);

    // R1 R8: reset clears a loaded bypass bit and the weights.
    set_faults_none();
    f_next[0][0] = 1;
    load_faults();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin w_m[r][c] = 0; f_m[r][c] = 0; end
    @(negedge clk);
    chk(y_valid == 1'b0, "R1 y_valid after second reset", int'(y_valid), 0);
    chk(y_vec == '0, "R1 y_vec cleared by reset", int'(y_vec[31:0]), 0);
    cur_req = "R1 zero weights";
    send(TBL[7]);
    idle_drain();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) w_next[r][c] = 3 - r + 2*c;
    load_weights();
    cur_req = "R8 reset cleared bypass";
    send(TBL[0]);
    idle_drain();

    chk(exp_q.size() == 0, "R5 every result delivered", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks,
             fails + mon_fails);
    $finish;
  end
endmodule